// File: doc/BRIEF.md
# Serial-Loaded Quad DAC Register Front End

This block is the digital side of a four-channel converter. It runs on a fast system clock and oversamples a serial clock, a serial data line and an active-low frame line. Each frame delivers a 16-bit word, most significant bit first. The word names a channel, a reference-buffer choice and a 12-bit code. A completed word lands in that channel's input register. An active-low load line then moves every input register into its DAC register. An active-low clear line zeroes all of them, and an active-low sleep line flags every output as high-impedance.

A chain-enable strap selects the mode. In standalone mode the word is decoded as soon as its sixteenth bit arrives. In daisy-chain mode bits keep shifting for as long as the frame lasts, and the last sixteen received are decoded when the frame closes. A serial output presents the top bit of the shift register, refreshed on every rising serial-clock edge. This lets a chain of parts pass data along, or lets the shift register be read back. All pin inputs pass through two-flop synchronizers. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `qdac_front`

## Requirements
- R1: After reset, every DAC code is zero, every reference-buffer output is 0, the serial output is 0, and hiZ is 0 while sleepN is high.
- R2: A standalone frame of 16 falling serial-clock edges, sent MSB first, writes the word. Bits 15:14 address the channel (0 to 3), bit 13 is its reference-buffer bit, bit 12 is don't-care, and bits 11:0 are the code. The word goes only into that channel's input register, and the DAC outputs do not change while loadN stays high.
- R3: While loadN is low, every DAC register (code and buffer bit) takes the value of its input register. If loadN is held low, a newly written word reaches the outputs without any further action.
- R4: If the frame line rises before the 16th falling edge, the partial word is discarded and no input register changes.
- R5: In standalone mode, falling edges after the 16th within the same frame change neither the decoded word nor the shift register.
- R6: In daisy-chain mode (chainEn high), shifting continues for any number of edges, and the last 16 bits are decoded when the frame line rises. A frame of fewer than 16 edges changes nothing.
- R7: The serial output changes only after a rising serial-clock edge, when it takes bit 15 of the shift register. In a chain it therefore replays earlier bits, delayed by 16 edges.
- R8: clearN low zeroes all input and DAC registers, including buffer bits, and it wins over a word that completes in the same cycle.
- R9: sleepN low drives hiZ high and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| serDin | input | 1 | Serial data input |
| frameN | input | 1 | Active-low frame line |
| loadN | input | 1 | Active-low transfer of input registers to DAC registers |
| clearN | input | 1 | Active-low clear of all registers |
| sleepN | input | 1 | Active-low power-down |
| chainEn | input | 1 | Static strap: 1 selects daisy-chain mode, 0 standalone |
| serDout | output | 1 | Serial output carrying shift-register bit 15 |
| dacCode | output | 48 | Four 12-bit DAC codes, channel 0 in the low bits |
| refBuf | output | 4 | Reference-buffer select per channel, from the DAC registers |
| hiZ | output | 1 | All outputs flagged high-impedance |

## Verification
Two functions can fall in the same system cycle: the commit of a finished standalone word and a clear. The bench starts a one-cycle clear pulse exactly one system clock after it drives the sixteenth falling edge. Both paths have the same synchronizer depth, and the commit lags the shift by one register, so the clear strobe and the commit strobe meet on the same edge. The bench judges the result at the ports. The DAC codes must read zero at once, and after a later load they must still read zero for every channel, the addressed one included. A second overlap, a commit while the load line is held low, is judged by the word showing up at the outputs without any load pulse.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // strobes from control to datapath, each valid for one system cycle
  typedef struct packed {
    logic shiftEn;
    logic sdoUpd;
    logic commit;
    logic clear;
    logic load;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_FULL
  } frame_st_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int N = 6,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] pinIn,
  output logic [N-1:0] syncOut
);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL[i]}};
        else       chain <= {chain[STAGES-2:0], pinIn[i]};
      end
      assign syncOut[i] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkS,
  input  logic    frameS,
  input  logic    loadS,
  input  logic    clearS,
  input  logic    chainEn,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic sclkPrev, framePrev;
  logic [CNT_W-1:0] bitCnt;
  frame_st_e state;

  logic sclkFall, sclkRise, frameRise, cntFull;

  assign sclkFall  = sclkPrev & ~sclkS;
  assign sclkRise  = ~sclkPrev & sclkS;
  assign frameRise = ~framePrev & frameS;
  assign cntFull   = (bitCnt == FULL_CNT);

  always_comb begin
    stb.shiftEn = ~frameS & sclkFall & (state != ST_FULL) & (chainEn | ~cntFull);
    stb.sdoUpd  = sclkRise;
    if (chainEn) stb.commit = frameRise & cntFull;
    else         stb.commit = ~frameS & (state == ST_COLLECT) & cntFull;
    stb.clear   = ~clearS;
    stb.load    = ~loadS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b1;
      framePrev <= 1'b1;
    end else begin
      sclkPrev  <= sclkS;
      framePrev <= frameS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (frameS) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      if (stb.shiftEn && !cntFull) bitCnt <= bitCnt + 1'b1;
      case (state)
        ST_IDLE:    state <= ST_COLLECT;
        ST_COLLECT: if (stb.commit) state <= ST_FULL;
        default:    state <= state;
      endcase
    end
  end

endmodule

// File: rtl/qdac_dpath.sv
module qdac_dpath
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dinS,
  input  strobe_t                  stb,
  output logic                     sdo,
  output logic [NUM_CH*DATA_W-1:0] dacCode,
  output logic [NUM_CH-1:0]        refBuf
);

  localparam int ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BUF_POS = WORD_W - 1 - ADDR_W;

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] wordAddr;
  logic              wordBuf;
  logic [DATA_W-1:0] wordCode;

  assign wordAddr = shiftReg[WORD_W-1 -: ADDR_W];
  assign wordBuf  = shiftReg[BUF_POS];
  assign wordCode = shiftReg[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], dinS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdo <= 1'b0;
    else if (stb.sdoUpd) sdo <= shiftReg[WORD_W-1];
  end

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [DATA_W-1:0] inCode, dacReg;
      logic              inBuf, dacBuf;
      logic              hit;

      assign hit = stb.commit && (wordAddr == ADDR_W'(ch));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          inCode <= '0;
          inBuf  <= 1'b0;
          dacReg <= '0;
          dacBuf <= 1'b0;
        end else if (stb.clear) begin
          inCode <= '0;
          inBuf  <= 1'b0;
          dacReg <= '0;
          dacBuf <= 1'b0;
        end else begin
          if (hit) begin
            inCode <= wordCode;
            inBuf  <= wordBuf;
          end
          if (stb.load) begin
            dacReg <= inCode;
            dacBuf <= inBuf;
          end
        end
      end

      assign dacCode[ch*DATA_W +: DATA_W] = dacReg;
      assign refBuf[ch] = dacBuf;
    end
  endgenerate

endmodule

// File: rtl/qdac_front.sv
module qdac_front
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serDin,
  input  logic                     frameN,
  input  logic                     loadN,
  input  logic                     clearN,
  input  logic                     sleepN,
  input  logic                     chainEn,
  output logic                     serDout,
  output logic [NUM_CH*DATA_W-1:0] dacCode,
  output logic [NUM_CH-1:0]        refBuf,
  output logic                     hiZ
);

  localparam int NPIN = 6;
  // order: sleep, clear, load, frame, din, sclk
  localparam logic [NPIN-1:0] PIN_IDLE = 6'b111101;

  logic [NPIN-1:0] pinRaw, pinS;
  strobe_t stb;

  assign pinRaw = {sleepN, clearN, loadN, frameN, serDin, serClk};

  qdac_sync #(.N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(pinRaw), .syncOut(pinS)
  );

  qdac_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkS(pinS[0]), .frameS(pinS[2]),
    .loadS(pinS[3]), .clearS(pinS[4]), .chainEn(chainEn), .stb(stb)
  );

  qdac_dpath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .dinS(pinS[1]), .stb(stb), .sdo(serDout),
    .dacCode(dacCode), .refBuf(refBuf)
  );

  assign hiZ = ~pinS[5];

endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     serClk,
  input logic                     loadN,
  input logic                     clearN,
  input logic                     sleepN,
  input logic                     serDout,
  input logic [NUM_CH*DATA_W-1:0] dacCode,
  input logic [NUM_CH-1:0]        refBuf,
  input logic                     hiZ
);

  logic [2:0] age;
  logic ready;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end
  assign ready = (age >= 3'd5);

  // R9: hiZ tracks the sleep pin through the synchronizer
  p_hiz_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (hiZ == !$past(sleepN, 2)));

  // R8: a clear seen at the pin empties the DAC registers
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(clearN, 3)) |-> (dacCode == '0 && refBuf == '0));

  // R2: without load or clear the DAC outputs hold
  p_dac_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(loadN, 3) && $past(clearN, 3)) |-> ($stable(dacCode) && $stable(refBuf)));

  // R7: serial output moves only after a serial clock rise
  p_sdo_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ready && ($past(serClk, 3) == $past(serClk, 4))) |-> $stable(serDout));

endmodule

bind qdac_front qdac_front_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .serClk(serClk), .loadN(loadN), .clearN(clearN),
  .sleepN(sleepN), .serDout(serDout), .dacCode(dacCode), .refBuf(refBuf), .hiZ(hiZ)
);

// File: tb/tb_qdac_front.sv
module tb_qdac_front;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b1, serDin = 1'b0, frameN = 1'b1, loadN = 1'b1;
  logic clearN = 1'b1, sleepN = 1'b1, chainEn = 1'b0;
  logic serDout, hiZ;
  logic [47:0] dacCode;
  logic [3:0] refBuf;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [11:0] mIn [4];
  logic [11:0] mDac [4];
  logic        mInB [4];
  logic        mDacB [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_front dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDin(serDin), .frameN(frameN),
    .loadN(loadN), .clearN(clearN), .sleepN(sleepN), .chainEn(chainEn),
    .serDout(serDout), .dacCode(dacCode), .refBuf(refBuf), .hiZ(hiZ)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(req, 32'(dacCode[c*12 +: 12]), 32'(mDac[c]));
      chk(req, 32'(refBuf[c]), 32'(mDacB[c]));
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input bit clrPulse);
    @(negedge clk);
    serDin = b;
    serClk = 1'b0;
    if (clrPulse) begin
      @(negedge clk); clearN = 1'b0;
      @(negedge clk); clearN = 1'b1;
      waitN(H - 2);
    end else begin
      waitN(H);
    end
    serClk = 1'b1;
    waitN(H - 1);
  endtask

  task automatic sendFrame(input logic [31:0] bits, input int n, input int clrAt);
    @(negedge clk); frameN = 1'b0;
    waitN(4);
    for (int i = n - 1; i >= 0; i--) sendBit(bits[i], (n - 1 - i) == clrAt);
    waitN(4);
    frameN = 1'b1;
    waitN(8);
  endtask

  function automatic logic [15:0] mkWord(input int ch, input logic b, input logic [11:0] code);
    return {2'(ch), b, 1'b0, code};
  endfunction

  task automatic writeWord(input int ch, input logic b, input logic [11:0] code);
    sendFrame(32'(mkWord(ch, b, code)), 16, -1);
    mIn[ch] = code;
    mInB[ch] = b;
  endtask

  task automatic pulseLoad();
    @(negedge clk); loadN = 1'b0;
    waitN(3);
    loadN = 1'b1;
    waitN(5);
    for (int c = 0; c < 4; c++) begin
      mDac[c] = mIn[c];
      mDacB[c] = mInB[c];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w1, w2, w;
    for (int c = 0; c < 4; c++) begin
      mIn[c] = '0; mDac[c] = '0; mInB[c] = 1'b0; mDacB[c] = 1'b0;
    end
    waitN(4);
    rstN = 1'b1;
    waitN(6);

    // R1 reset state
    chkAll("R1");
    chk("R1", 32'(serDout), 0);
    chk("R1", 32'(hiZ), 0);

    // R2 / R3 sweep over channels, codes and buffer bits
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 6; k++) begin
        logic [11:0] code;
        code = 12'((ch * 1237 + k * 389 + 5) % 4096);
        if (k == 4) code = 12'hFFF;
        if (k == 5) code = 12'h000;
        writeWord(ch, 1'((ch + k) % 2), code);
        chkAll("R2");
        pulseLoad();
        chkAll("R3");
      end
    end

    // R3 load held low: outputs follow a new word directly
    @(negedge clk); loadN = 1'b0;
    waitN(4);
    writeWord(2, 1'b1, 12'hA5C);
    waitN(4);
    for (int c = 0; c < 4; c++) begin mDac[c] = mIn[c]; mDacB[c] = mInB[c]; end
    chkAll("R3");
    loadN = 1'b1;
    waitN(4);

    // R4 aborted frame of 10 bits changes nothing
    sendFrame(32'(mkWord(1, 1'b1, 12'h777)), 10, -1);
    pulseLoad();
    chkAll("R4");

    // R5 extra falls in standalone are ignored
    w = mkWord(0, 1'b1, 12'h3C5);
    sendFrame({12'h0, w, 4'b1111}, 20, -1);
    mIn[0] = 12'h3C5; mInB[0] = 1'b1;
    chk("R5", 32'(serDout), 32'(w[15]));
    pulseLoad();
    chkAll("R5");

    // R8 clear coinciding with a word commit
    sendFrame(32'(mkWord(1, 1'b1, 12'h9E1)), 16, 15);
    for (int c = 0; c < 4; c++) begin
      mIn[c] = '0; mInB[c] = 1'b0; mDac[c] = '0; mDacB[c] = 1'b0;
    end
    chkAll("R8");
    pulseLoad();
    chkAll("R8");

    // R8 plain clear
    writeWord(3, 1'b1, 12'h5A5);
    pulseLoad();
    chkAll("R8");
    @(negedge clk); clearN = 1'b0;
    waitN(3);
    clearN = 1'b1;
    waitN(4);
    for (int c = 0; c < 4; c++) begin
      mIn[c] = '0; mInB[c] = 1'b0; mDac[c] = '0; mDacB[c] = 1'b0;
    end
    chkAll("R8");

    // R9 sleep
    writeWord(0, 1'b1, 12'h8F0);
    pulseLoad();
    @(negedge clk); sleepN = 1'b0;
    waitN(4);
    chk("R9", 32'(hiZ), 1);
    chkAll("R9");
    sleepN = 1'b1;
    waitN(4);
    chk("R9", 32'(hiZ), 0);

    // R6 / R7 daisy chain, 32 bits, SDO replays the first word
    chainEn = 1'b1;
    w1 = mkWord(0, 1'b0, 12'h123);
    w2 = mkWord(3, 1'b0, 12'hABC);
    @(negedge clk); frameN = 1'b0;
    waitN(4);
    for (int i = 15; i >= 0; i--) sendBit(w1[i], 1'b0);
    for (int k = 0; k < 16; k++) begin
      sendBit(w2[15 - k], 1'b0);
      if (k < 15) chk("R7", 32'(serDout), 32'(w1[14 - k]));
    end
    waitN(4);
    frameN = 1'b1;
    waitN(8);
    mIn[3] = 12'hABC; mInB[3] = 1'b0;
    pulseLoad();
    chkAll("R6");

    // R6 short daisy frame ignored
    sendFrame(32'(mkWord(2, 1'b0, 12'h111)), 10, -1);
    pulseLoad();
    chkAll("R6");

    // R6 20-bit daisy frame keeps the last 16
    w = mkWord(1, 1'b1, 12'hC3A);
    sendFrame({12'h0, 4'b1010, w}, 20, -1);
    mIn[1] = 12'hC3A; mInB[1] = 1'b1;
    pulseLoad();
    chkAll("R6");
    chainEn = 1'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule